// File: doc/BRIEF.md
# Key-Protected Trap Base Register

This block keeps the 32-bit base address of the CPU trap table and drives it continuously to the core. A plain synchronous register bus reaches it. That bus carries an address, separate byte and halfword write strobes, 16-bit write data and a registered 16-bit read data return.

The base address is guarded by an unlock gate. A write to the byte-wide guard register either opens the gate, when the byte equals 0x59, or closes it, for every other value. While the gate is open, halfword writes to the two base halves take effect. While it is closed, those writes are dropped and nothing else happens. The bottom ten address bits are hard zero, so the trap table is always aligned to 1 KiB.

The low halfword sits at offset `BASE_OFS` and keeps base bits [15:10] in its data bits [15:10]. The high halfword sits at `BASE_OFS+2` and keeps bits [31:16]. The guard register sits at `KEY_OFS`.

Top module: `trap_base_regs`

## Requirements
- R1: While `rst` is high at a clock edge, the gate closes and `trap_base` takes the value `RST_BASE` with bits [9:0] forced to zero. The default `RST_BASE` is 0x0020FC00.
- R2: A byte or halfword write to `KEY_OFS` whose `bus_wdata[7:0]` equals 0x59 opens the gate from the next cycle on.
- R3: A write to `KEY_OFS` with any other `bus_wdata[7:0]` closes the gate from the next cycle on.
- R4: Base bits [9:0] always read as zero and drive `trap_base[9:0]` as zero. Ones written to data bits [9:0] of the low half are discarded.
- R5: While the gate is closed, halfword writes to either base half leave `trap_base` and the read-back values unchanged.
- R6: While the gate is open, a halfword write to `BASE_OFS` loads `bus_wdata[15:10]` into base bits [15:10]. A halfword write to `BASE_OFS+2` loads `bus_wdata` into base bits [31:16]. The change is visible on `trap_base` on the next cycle.
- R7: The gate stays open across any number of base writes until a non-key byte is written to `KEY_OFS`.
- R8: Byte writes to either base half have no effect, whatever the state of the gate.
- R9: `bus_rdata` is registered. It shows, one cycle after `bus_addr` is presented, the low half as {bits[15:10], 10'b0}, the high half as bits [31:16], and zero for `KEY_OFS` and for unmapped offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we_byte | input | 1 | Byte write strobe (data in bits [7:0]) |
| bus_we_half | input | 1 | Halfword write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| trap_base | output | 32 | Current trap table base address to the core |

## Verification
A gate that is stuck or decoded wrong shows at the ports within two cycles of the next base write. `trap_base` either moves when it must not, or holds when it should move, and a read of either half reveals the same error. Every one of the 256 guard values is followed by writes to both halves, so a key comparison that is wrong at any single bit pattern is exposed at that value. A masking fault in the low half shows as nonzero bits [9:0], both on the read-back and on `trap_base`, one cycle after the write.

// File: rtl/trap_base_pkg.sv
package trap_base_pkg;
  localparam logic [7:0] UNLOCK_KEY = 8'h59;
  localparam int ALIGN_BITS = 10;
  localparam int LO_W = 16 - ALIGN_BITS;
  localparam int HI_W = 16;

  function automatic logic [31:0] align_base(input logic [31:0] a);
    return {a[31:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  endfunction
endpackage

// File: rtl/tbr_key_guard.sv
module tbr_key_guard
  import trap_base_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  output logic       open
);
  always_ff @(posedge clk) begin
    if (rst)         open <= 1'b0;
    else if (key_wr) open <= (key_byte == UNLOCK_KEY);
  end

  // R1: the gate is closed after reset
  a_r1_reset_closed: assert property (@(posedge clk) rst |=> !open);
  // R2: the key value opens the gate
  a_r2_key_opens: assert property (@(posedge clk) disable iff (rst)
    (key_wr && key_byte == 8'h59) |=> open);
  // R3: any other value closes it
  a_r3_other_closes: assert property (@(posedge clk) disable iff (rst)
    (key_wr && key_byte != 8'h59) |=> !open);
  // R7: without a guard write the state persists
  a_r7_persist: assert property (@(posedge clk) disable iff (rst)
    (!key_wr) |=> $stable(open));
endmodule

// File: rtl/tbr_half_reg.sv
module tbr_half_reg #(
  parameter int             W   = 16,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST;
    else if (we) q <= d;
  end
endmodule

// File: rtl/trap_base_regs.sv
module trap_base_regs
  import trap_base_pkg::*;
#(
  parameter int                 ADDR_W   = 4,
  parameter logic [ADDR_W-1:0]  KEY_OFS  = 4'h0,
  parameter logic [ADDR_W-1:0]  BASE_OFS = 4'h4,
  parameter logic [31:0]        RST_BASE = 32'h0020_FC00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we_byte,
  input  logic              bus_we_half,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic [31:0]       trap_base
);
  localparam logic [ADDR_W-1:0] BASE_HI_OFS = BASE_OFS + ADDR_W'(2);
  localparam logic [31:0]       RST_ALIGNED = align_base(RST_BASE);

  logic       gate_open;
  logic       key_wr;
  logic [1:0] half_we;
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;

  assign key_wr     = (bus_we_byte || bus_we_half) && (bus_addr == KEY_OFS);
  assign half_we[0] = bus_we_half && gate_open && (bus_addr == BASE_OFS);
  assign half_we[1] = bus_we_half && gate_open && (bus_addr == BASE_HI_OFS);

  tbr_key_guard u_guard (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (key_wr),
    .key_byte (bus_wdata[7:0]),
    .open     (gate_open)
  );

  for (genvar g = 0; g < 2; g++) begin : g_half
    if (g == 0) begin : g_lo
      tbr_half_reg #(.W(LO_W), .RST(RST_ALIGNED[15:ALIGN_BITS])) u_reg (
        .clk (clk), .rst (rst), .we (half_we[g]),
        .d   (bus_wdata[15:ALIGN_BITS]), .q (lo_q)
      );
    end else begin : g_hi
      tbr_half_reg #(.W(HI_W), .RST(RST_ALIGNED[31:16])) u_reg (
        .clk (clk), .rst (rst), .we (half_we[g]),
        .d   (bus_wdata), .q (hi_q)
      );
    end
  end

  assign trap_base = {hi_q, lo_q, {ALIGN_BITS{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_addr == BASE_OFS)    bus_rdata <= {lo_q, {ALIGN_BITS{1'b0}}};
    else if (bus_addr == BASE_HI_OFS) bus_rdata <= hi_q;
    else                              bus_rdata <= '0;
  end

  // R1: reset value of the base address
  a_r1_reset_base: assert property (@(posedge clk) rst |=> trap_base == RST_ALIGNED);
  // R5: closed gate keeps the base
  a_r5_locked_hold: assert property (@(posedge clk) disable iff (rst)
    (!gate_open && bus_we_half) |=> $stable(trap_base));
  // R8: byte writes never change the base
  a_r8_byte_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_we_byte && !bus_we_half) |=> $stable(trap_base));
  // R9: guard register reads as zero
  a_r9_key_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == KEY_OFS) |=> bus_rdata == 16'h0000);
endmodule

// File: tb/trap_base_regs_tb.sv
module trap_base_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] KEY = 4'h0, LO = 4'h4, HI = 4'h6, NONE = 4'hA;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we_byte = 1'b0, bus_we_half = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [31:0] trap_base;

  int applied = 0, bad = 0;
  logic [31:0] exp_base;
  logic        exp_open;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_base_regs u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we_byte(bus_we_byte),
    .bus_we_half(bus_we_half), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trap_base(trap_base)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic half);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we_half = half; bus_we_byte = !half;
    @(negedge clk);
    bus_we_half = 1'b0; bus_we_byte = 1'b0; bus_addr = NONE;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // model of a base write
  task automatic base_wr(input logic [3:0] a, input logic [15:0] d, input logic half);
    wr(a, d, half);
    if (half && exp_open) begin
      if (a == LO) exp_base[15:10] = d[15:10];
      if (a == HI) exp_base[31:16] = d;
    end
  endtask

  task automatic check_all(input string req);
    logic [15:0] r;
    chk(req, trap_base, exp_base);
    rd(LO, r); chk(req, {16'h0, r}, {16'h0, exp_base[15:10], 10'h000});
    rd(HI, r); chk(req, {16'h0, r}, {16'h0, exp_base[31:16]});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; applied++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin : stim
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_base = 32'h0020_FC00; exp_open = 1'b0;
    // R1 reset state, gate closed
    check_all("R1");
    base_wr(LO, 16'h0000, 1'b1); base_wr(HI, 16'h1234, 1'b1);
    check_all("R1_closed_after_reset");

    // R2 R3 R4 R5 R6: sweep every guard value
    for (int v = 0; v < 256; v++) begin
      wr(KEY, {8'hA5, v[7:0]}, v[0]);
      exp_open = (v[7:0] == 8'h59);
      base_wr(LO, {v[5:0], 10'h3FF}, 1'b1);
      base_wr(HI, ~{v[7:0], v[7:0]}, 1'b1);
      check_all(exp_open ? "R2_R6_R4" : "R3_R5");
    end

    // R7 unlock persists over many writes
    wr(KEY, 16'h0059, 1'b0); exp_open = 1'b1;
    for (int i = 0; i < 8; i++) begin
      base_wr(LO, 16'h0400 * i[15:0] | 16'h0155, 1'b1);
      base_wr(HI, 16'h1111 * i[15:0], 1'b1);
      check_all("R7");
    end

    // R8 byte writes ignored while open
    base_wr(LO, 16'hFFFF, 1'b0);
    base_wr(HI, 16'hBEEF, 1'b0);
    check_all("R8");

    // R9 guard and unmapped offsets read zero
    rd(KEY, r); chk("R9_key", {16'h0, r}, 32'h0);
    rd(NONE, r); chk("R9_unmapped", {16'h0, r}, 32'h0);

    // R3 relock then writes dropped
    wr(KEY, 16'h0058, 1'b0); exp_open = 1'b0;
    base_wr(HI, 16'h5555, 1'b1);
    check_all("R3_R5_relock");

    // R1 reset mid-run restores base and closes gate
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    exp_base = 32'h0020_FC00;
    base_wr(LO, 16'h0000, 1'b1);
    check_all("R1_rerun");

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule